// File: doc/BRIEF.md
# I2C Slave Register-Write Port

This block is a slave on a two-wire I2C bus inside a control chip. Both bus lines pass through a synchroniser and a glitch filter that run on the system clock. Edge and condition detectors feed a byte-framing state machine. Writes from the master leave the block as single-cycle register-write pulses that carry an 8-bit address and an 8-bit data byte. A read returns two status bytes, which the surrounding logic supplies on two input buses.

A write transaction can take three shapes. The simplest is one register index followed by one data byte. The master can also send a run of index/data pairs without stopping. If the index byte has its top bit set, the block switches to auto-increment mode: the low seven bits become a starting pointer, and every byte after it is data for the next register in turn. A read has no index phase. Once the slave has acknowledged the address byte, it sends status byte one and then status byte two, and after that it goes quiet.

The state machine has nine states. IDLE waits for a start. ADDR shifts in the address byte. SUB shifts in an index byte. DATA shifts in the data byte of a pair. AUTO shifts in data bytes in pointer mode. ACK drives the ninth-clock acknowledge. TX shifts a status byte out. RACK samples the master's acknowledge. IGNORE keeps SDA released until the next start. Transitions:
- A start condition leads from any state to ADDR.
- A stop condition leads from any state to IDLE.
- When an address byte completes, the block goes to ACK if the address matches and to IGNORE if it does not.
- From ACK, the next state depends on the byte just acknowledged:
  - after the address byte: TX for a read, SUB for a write;
  - after an index byte: DATA, or AUTO if the mode flag is set;
  - after a DATA byte: back to SUB;
  - after an AUTO byte: back to AUTO.
- After eight bits, TX goes to RACK.
- From RACK, a master acknowledge on the first byte leads back to TX. A NACK, or the end of the second byte, leads to IGNORE.

Top module: `i2c_regwr_slave`

## Requirements
- R1: The first byte after a start is a 7-bit device address, sent MSB first, followed by a direction bit (0 = write, 1 = read). When the address equals DEV_ADDR, the slave pulls SDA low during the ninth SCL clock.
- R2: When the address does not match, sda_oe stays 0 for the rest of the transaction and no wr_stb is produced.
- R3: In a write, a byte with bit 7 = 0 that follows the address is a register index, and the next byte is data. Both bytes are acknowledged, and the pair produces exactly one wr_stb with wr_addr = index and wr_data = data.
- R4: Within one write transaction, index and data bytes keep alternating until a stop. Each pair produces one wr_stb, in the order sent.
- R5: An index byte with bit 7 = 1 loads its low 7 bits as a pointer. Every following byte is data: it is written to {1'b0, pointer}, and the pointer then advances by one modulo 128.
- R6: A read has no index phase. After the address acknowledge, the slave sends stat1_i and then stat2_i, both MSB first. Each value is captured at the SCL fall that ends the preceding acknowledge clock.
- R7: A master NACK, or the end of the second status byte, releases SDA until the next start. Any further bytes the master clocks in read as 0xFF.
- R8: A start or stop condition restarts byte framing. A byte cut short by a repeated start or a stop produces no write.
- R9: wr_stb lasts exactly one system clock. It is issued at the SCL fall that ends the data byte's acknowledge clock, so it occurs while SCL is low.
- R10: sda_oe changes only while SCL is low. Each change comes at least HOLD_CYC system clocks after the SCL fall.
- R11: While rst_n is low, sda_oe and wr_stb are 0 and the framing is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| stat1_i | input | 8 | First status byte returned on reads |
| stat2_i | input | 8 | Second status byte returned on reads |
| wr_stb | output | 1 | One-cycle register-write strobe |
| wr_addr | output | 8 | Register address for wr_stb |
| wr_data | output | 8 | Register data for wr_stb |

## Verification
The assertions assume a well-behaved bus. SCL stays in each phase much longer than the filter delay plus HOLD_CYC. SDA changes only while SCL is low, except at start and stop conditions. The master never makes a start or stop while the slave is holding SDA low. The bench master meets these assumptions: each SCL phase lasts 60 system clocks, data changes a quarter period after SCL falls, and conditions are only generated while SDA is released. A bench monitor timestamps every sda_oe change against the bench's own SCL drive.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_DATA,
        ST_AUTO,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_IGNORE
    } slv_state_t;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            hist_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q)
                dout <= 1'b1;
            else if (~|hist_q)
                dout <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic cond_start,
    output logic cond_stop
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign scl_rise   = scl & ~scl_q;
    assign scl_fall   = ~scl & scl_q;
    assign cond_start = scl & scl_q & sda_q & ~sda;
    assign cond_stop  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2c_regwr_slave.sv
module i2c_regwr_slave
    import i2c_regwr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h45,
    parameter int         FILT_LEN = 3,
    parameter int         HOLD_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [7:0] stat1_i,
    input  logic [7:0] stat2_i,
    output logic       wr_stb,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [1:0] raw_ln, filt_ln;
    assign raw_ln = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        i2c_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .din(raw_ln[g]), .dout(filt_ln[g])
        );
    end

    logic scl_f, sda_f, ev_rise, ev_fall, ev_start, ev_stop;
    assign scl_f = filt_ln[0];
    assign sda_f = filt_ln[1];

    i2c_bus_events u_ev (
        .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
        .scl_rise(ev_rise), .scl_fall(ev_fall),
        .cond_start(ev_start), .cond_stop(ev_stop)
    );

    slv_state_t state, after_ack;
    logic [3:0] cnt;
    logic [7:0] rx_sh, tx_sh, ptr, dat;
    logic       wr_pend, rd_second, m_nack;
    logic       drive_req;
    logic [HW-1:0] hold_cnt;
    logic       hold_run;

    // state register and framing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            after_ack <= ST_IDLE;
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '1;
            ptr       <= '0;
            dat       <= '0;
            wr_pend   <= 1'b0;
            rd_second <= 1'b0;
            m_nack    <= 1'b0;
            wr_stb    <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (ev_start) begin
                state   <= ST_ADDR;
                cnt     <= '0;
                wr_pend <= 1'b0;
            end else if (ev_stop) begin
                state   <= ST_IDLE;
                cnt     <= '0;
                wr_pend <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_IGNORE: ;
                    ST_ADDR, ST_SUB, ST_DATA, ST_AUTO: begin
                        if (ev_rise && cnt < 4'd8) begin
                            rx_sh <= {rx_sh[6:0], sda_f};
                            cnt   <= cnt + 4'd1;
                        end else if (ev_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            unique case (state)
                                ST_ADDR: begin
                                    if (rx_sh[7:1] == DEV_ADDR) begin
                                        state     <= ST_ACK;
                                        after_ack <= rx_sh[0] ? ST_TX : ST_SUB;
                                    end else begin
                                        state <= ST_IGNORE;
                                    end
                                end
                                ST_SUB: begin
                                    state <= ST_ACK;
                                    if (rx_sh[7]) begin
                                        ptr       <= {1'b0, rx_sh[6:0]};
                                        after_ack <= ST_AUTO;
                                    end else begin
                                        ptr       <= rx_sh;
                                        after_ack <= ST_DATA;
                                    end
                                end
                                ST_DATA: begin
                                    dat       <= rx_sh;
                                    wr_pend   <= 1'b1;
                                    state     <= ST_ACK;
                                    after_ack <= ST_SUB;
                                end
                                default: begin
                                    dat       <= rx_sh;
                                    wr_pend   <= 1'b1;
                                    state     <= ST_ACK;
                                    after_ack <= ST_AUTO;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (ev_fall) begin
                            state <= after_ack;
                            if (wr_pend) begin
                                wr_stb  <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= dat;
                                wr_pend <= 1'b0;
                                if (after_ack == ST_AUTO)
                                    ptr <= {1'b0, ptr[6:0] + 7'd1};
                            end
                            if (after_ack == ST_TX) begin
                                tx_sh     <= stat1_i;
                                rd_second <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (ev_fall) begin
                            if (cnt == 4'd8) begin
                                state <= ST_RACK;
                                cnt   <= '0;
                            end else begin
                                tx_sh <= {tx_sh[6:0], 1'b1};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev_rise) begin
                            m_nack <= sda_f;
                        end else if (ev_fall) begin
                            if (m_nack || rd_second) begin
                                state <= ST_IGNORE;
                            end else begin
                                rd_second <= 1'b1;
                                tx_sh     <= stat2_i;
                                state     <= ST_TX;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // drive request decoded from the state
    always_comb begin
        unique case (state)
            ST_ACK:  drive_req = 1'b1;
            ST_TX:   drive_req = ~tx_sh[7];
            default: drive_req = 1'b0;
        endcase
    end

    // SDA output, updated HOLD_CYC clocks after each SCL fall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe   <= 1'b0;
            hold_cnt <= '0;
            hold_run <= 1'b0;
        end else if (ev_start || ev_stop) begin
            sda_oe   <= 1'b0;
            hold_run <= 1'b0;
        end else if (ev_fall) begin
            hold_cnt <= HW'(HOLD_CYC - 1);
            hold_run <= 1'b1;
        end else if (hold_run) begin
            if (hold_cnt == '0) begin
                sda_oe   <= drive_req;
                hold_run <= 1'b0;
            end else begin
                hold_cnt <= hold_cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_regwr_chk.sv
module i2c_regwr_chk
    import i2c_regwr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       wr_stb,
    input slv_state_t st
);
    // R11
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!sda_oe && !wr_stb));

    // R9
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !wr_stb);

    // R9
    stb_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> !scl_i);

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R2
    ignore_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGNORE) |-> !sda_oe);
endmodule

bind i2c_regwr_slave i2c_regwr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .wr_stb(wr_stb), .st(state)
);

// File: tb/test_i2c_regwr_slave.sv
module test_i2c_regwr_slave;
    localparam logic [6:0] DEV = 7'h45;
    localparam int HOLD = 16;
    localparam int Q = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [7:0] stat1 = 8'h00, stat2 = 8'h00;
    logic sda_oe, wr_stb;
    logic [7:0] wr_addr, wr_data;
    wire sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_regwr_slave #(.DEV_ADDR(DEV), .FILT_LEN(3), .HOLD_CYC(HOLD)) i_i2c_regwr_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .stat1_i(stat1), .stat2_i(stat2), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int total = 0, bad = 0;
    int nlog = 0;
    logic [7:0] log_a [64];
    logic [7:0] log_d [64];
    int since_fall = 0;
    int hold_bad = 0;
    logic oe_prev = 1'b0;
    logic oe_seen = 1'b0;

    always @(negedge clk) begin
        if (wr_stb && nlog < 64) begin
            log_a[nlog] = wr_addr;
            log_d[nlog] = wr_data;
            nlog = nlog + 1;
        end
        if (sda_oe) oe_seen = 1'b1;
        if (sda_oe != oe_prev && (scl_m || since_fall < HOLD)) hold_bad = hold_bad + 1;
        oe_prev = sda_oe;
        if (scl_m) since_fall = 0; else since_fall = since_fall + 1;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic bstop();
        sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(2*Q);
    endtask

    task automatic wbit(input logic b);
        sda_m = b; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic rbit(output logic v);
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); v = sda_line; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic v;
        for (int i = 7; i >= 0; i--) wbit(b[i]);
        rbit(v);
        ack = ~v;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] b);
        logic v;
        for (int i = 7; i >= 0; i--) begin
            rbit(v);
            b[i] = v;
        end
        wbit(~m_ack);
    endtask

    initial begin
        logic ack;
        logic [7:0] rb;
        int base;
        w(5);
        // R11
        chk(sda_oe == 1'b0, "R11 sda_oe in reset", sda_oe, 0);
        chk(wr_stb == 1'b0, "R11 wr_stb in reset", wr_stb, 0);
        rst_n = 1'b1;
        w(20);

        // R1 R3: single pair sweep
        for (int k = 0; k < 5; k++) begin
            logic [7:0] sub, dt;
            sub = 8'((k * 29) & 8'h7F);
            dt  = 8'(sub * 3 + 7);
            base = nlog;
            bstart();
            send_byte({DEV, 1'b0}, ack); chk(ack, "R1 write address ack", ack, 1);
            send_byte(sub, ack);         chk(ack, "R3 index ack", ack, 1);
            send_byte(dt, ack);          chk(ack, "R3 data ack", ack, 1);
            bstop();
            chk(nlog == base + 1, "R3 strobe count", nlog - base, 1);
            chk(log_a[base] == sub && log_d[base] == dt, "R3 strobe addr/data",
                {log_a[base], log_d[base]}, {sub, dt});
        end

        // R4: chained pairs
        base = nlog;
        bstart();
        send_byte({DEV, 1'b0}, ack);
        for (int k = 0; k < 4; k++) begin
            send_byte(8'(8'h10 + k), ack);
            send_byte(8'(~(k * 17)), ack);
        end
        bstop();
        chk(nlog == base + 4, "R4 chained strobe count", nlog - base, 4);
        for (int k = 0; k < 4; k++)
            chk(log_a[base+k] == 8'(8'h10 + k) && log_d[base+k] == 8'(~(k * 17)),
                "R4 chained pair", {log_a[base+k], log_d[base+k]}, {8'(8'h10 + k), 8'(~(k * 17))});

        // R5: auto-increment with wrap, two start points
        for (int s = 0; s < 2; s++) begin
            logic [6:0] st;
            st = (s == 0) ? 7'h7E : 7'h30;
            base = nlog;
            bstart();
            send_byte({DEV, 1'b0}, ack);
            send_byte({1'b1, st}, ack);
            for (int k = 0; k < 5; k++) begin
                send_byte(8'(k * 41 + 3), ack);
                chk(ack, "R5 auto data ack", ack, 1);
            end
            bstop();
            chk(nlog == base + 5, "R5 auto strobe count", nlog - base, 5);
            for (int k = 0; k < 5; k++)
                chk(log_a[base+k] == {1'b0, 7'(st + k)} && log_d[base+k] == 8'(k * 41 + 3),
                    "R5 auto addr/data", {log_a[base+k], log_d[base+k]},
                    {1'b0, 7'(st + k), 8'(k * 41 + 3)});
        end

        // R2: wrong addresses
        for (int k = 0; k < 2; k++) begin
            logic [6:0] wa;
            wa = (k == 0) ? (DEV ^ 7'h01) : (DEV ^ 7'h40);
            base = nlog;
            oe_seen = 1'b0;
            bstart();
            send_byte({wa, 1'b0}, ack); chk(!ack, "R2 foreign address nack", ack, 0);
            send_byte(8'h05, ack);
            send_byte(8'h99, ack);
            bstop();
            chk(!oe_seen, "R2 sda never driven", oe_seen, 0);
            chk(nlog == base, "R2 no strobe", nlog - base, 0);
        end

        // R6 R7: reads, then extra byte reads released bus
        for (int k = 0; k < 6; k++) begin
            logic [7:0] e1, e2;
            e1 = 8'(k * 37 + 1);
            e2 = 8'(~(k * 53));
            stat1 = e1; stat2 = e2;
            bstart();
            send_byte({DEV, 1'b1}, ack); chk(ack, "R1 read address ack", ack, 1);
            recv_byte(1'b1, rb);         chk(rb == e1, "R6 status byte 1", rb, e1);
            recv_byte(k[0], rb);         chk(rb == e2, "R6 status byte 2", rb, e2);
            recv_byte(1'b0, rb);         chk(rb == 8'hFF, "R7 released after two bytes", rb, 8'hFF);
            bstop();
        end

        // R7: NACK after first byte
        stat1 = 8'h00; stat2 = 8'h00;
        bstart();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b0, rb); chk(rb == 8'h00, "R6 status byte 1 zero", rb, 0);
        recv_byte(1'b0, rb); chk(rb == 8'hFF, "R7 released after NACK", rb, 8'hFF);
        bstop();

        // R8: repeated start mid data byte, then stop mid index byte
        base = nlog;
        bstart();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h22, ack);
        for (int i = 0; i < 4; i++) wbit(1'b0);
        bstart();
        send_byte({DEV, 1'b0}, ack); chk(ack, "R8 address after repeated start", ack, 1);
        send_byte(8'h33, ack);
        for (int i = 0; i < 3; i++) wbit(1'b1);
        bstop();
        chk(nlog == base, "R8 no write for partial bytes", nlog - base, 0);
        bstart();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h44, ack);
        send_byte(8'hA5, ack);
        bstop();
        chk(nlog == base + 1 && log_a[base] == 8'h44 && log_d[base] == 8'hA5,
            "R8 framing recovered", {log_a[base], log_d[base]}, {8'h44, 8'hA5});

        // R10
        chk(hold_bad == 0, "R10 sda_oe change timing", hold_bad, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule